// File: doc/BRIEF.md
# Binary/Decimal 8-bit Adder-Subtractor

This block adds two bytes with an incoming carry, or subtracts one byte from another with an incoming borrow. It is purely combinational. A decimal-mode input selects how the bytes are treated. When it is low, both operations are plain two's-complement binary arithmetic. When it is high, each byte holds two packed BCD digits, and the sum or difference is corrected to valid BCD inside the block.

The carry output means the same thing in both modes. It is the carry out of an addition, or the inverted borrow of a subtraction. For subtraction, the carry input is also an inverted borrow: 1 means nothing is borrowed. In binary mode the block also produces zero, overflow and negative flags, and it marks them valid. In decimal mode those three flags carry no meaning, and the valid output drops low.

The datapath is a chain of 4-bit digit cells. Each cell does its own decimal correction and passes a digit carry to the cell above it.

Top module: `dec_bin_addsub`

## Requirements
- R1: With `dec_i`=0 and `sub_i`=0, `{carry_o, res_o}` equals `a_i + b_i + carry_i` as a 9-bit binary sum.
- R2: With `dec_i`=0 and `sub_i`=1, `res_o` equals `a_i - b_i - (1 - carry_i)` modulo 256. `carry_o` is 1 exactly when that difference is not negative.
- R3: With `dec_i`=0, `ovf_o` is 1 exactly when `a_i` and the effective second operand have the same sign bit (bit 7) and `res_o` has the other sign. The effective second operand is `b_i` for addition and `~b_i` for subtraction.
- R4: With `dec_i`=0, `neg_o` equals `res_o[7]`, and `zero_o` is 1 exactly when `res_o` is 0x00.
- R5: With `dec_i`=1 and `sub_i`=0, and both operands valid packed BCD (upper digit in bits 7:4, lower digit in bits 3:0, each 0 to 9), `res_o` is the BCD encoding of `(A + B + carry_i) mod 100`. `carry_o` is 1 exactly when the decimal sum is 100 or more.
- R6: With `dec_i`=1 and `sub_i`=1, and valid BCD operands, `res_o` is the BCD encoding of `(A - B - (1 - carry_i)) mod 100`. `carry_o` is 1 exactly when the decimal difference is not negative.
- R7: `flags_valid_o` is 1 when `dec_i`=0 and 0 when `dec_i`=1.
- R8: All outputs depend only on the present inputs. A new input set is fully reflected at the outputs within the same cycle, with no state held between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand; the subtrahend when subtracting |
| carry_i | input | 1 | Carry in for addition; inverted borrow for subtraction |
| sub_i | input | 1 | 0 selects addition, 1 selects subtraction |
| dec_i | input | 1 | 0 selects binary mode, 1 selects packed-BCD mode |
| res_o | output | 8 | Result byte |
| carry_o | output | 1 | Carry out, or inverted borrow out |
| zero_o | output | 1 | Result is zero (meaningful only when flags_valid_o is 1) |
| ovf_o | output | 1 | Signed overflow (meaningful only when flags_valid_o is 1) |
| neg_o | output | 1 | Result bit 7 (meaningful only when flags_valid_o is 1) |
| flags_valid_o | output | 1 | Zero, overflow and negative flags are meaningful |

## Verification
The bench builds the block with its default width of 8 bits, which gives two digit cells. At that width the input space is small enough to cover the binary operand space exhaustively: all 65,536 operand pairs, with the operation and carry-in taken from the operand bits. The bench also covers every pair of valid two-digit BCD operands under both operations and both carry-in values. That exercises every digit carry and borrow between the cells, including the 99+99+1 and 00-99-1 wrap cases.

// File: rtl/dec_bin_addsub_pkg.sv
package dec_bin_addsub_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;
  localparam logic [DIGIT_W-1:0] BCD_ADJ = DIGIT_W'(6);
endpackage

// File: rtl/digit_cell.sv
module digit_cell
  import dec_bin_addsub_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               carry_i,
  input  logic               sub_i,
  input  logic               dec_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               carry_o
);
  logic [DIGIT_W-1:0] b_eff;
  logic [DIGIT_W:0]   raw;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    raw   = {1'b0, a_i} + {1'b0, b_eff} + {{DIGIT_W{1'b0}}, carry_i};
    if (!dec_i) begin
      digit_o = raw[DIGIT_W-1:0];
      carry_o = raw[DIGIT_W];
    end else if (!sub_i) begin
      // decimal add: a digit sum above nine wraps by adding six
      carry_o = (raw > (DIGIT_W+1)'(DIGIT_MAX));
      digit_o = carry_o ? raw[DIGIT_W-1:0] + BCD_ADJ : raw[DIGIT_W-1:0];
    end else begin
      // decimal subtract: a digit borrow pulls six off the wrapped value
      carry_o = raw[DIGIT_W];
      digit_o = carry_o ? raw[DIGIT_W-1:0] : raw[DIGIT_W-1:0] - BCD_ADJ;
    end
  end

  logic bcd_in;
  always_comb begin
    bcd_in = dec_i && (a_i <= DIGIT_W'(DIGIT_MAX)) && (b_i <= DIGIT_W'(DIGIT_MAX));
    if (bcd_in && !sub_i)
      a_r5_digit_bcd: assert (digit_o <= DIGIT_W'(DIGIT_MAX));
    if (bcd_in && sub_i)
      a_r6_digit_bcd: assert (digit_o <= DIGIT_W'(DIGIT_MAX));
  end
endmodule

// File: rtl/dec_bin_addsub.sv
module dec_bin_addsub
  import dec_bin_addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic             sub_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             flags_valid_o
);
  localparam int unsigned DIGITS = WIDTH / DIGIT_W;

  logic [DIGITS:0] chain;
  assign chain[0] = carry_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    digit_cell i_cell (
      .a_i     (a_i[g*DIGIT_W +: DIGIT_W]),
      .b_i     (b_i[g*DIGIT_W +: DIGIT_W]),
      .carry_i (chain[g]),
      .sub_i   (sub_i),
      .dec_i   (dec_i),
      .digit_o (res_o[g*DIGIT_W +: DIGIT_W]),
      .carry_o (chain[g+1])
    );
  end

  logic msb_b;
  always_comb begin
    msb_b         = b_i[WIDTH-1] ^ sub_i;
    carry_o       = chain[DIGITS];
    neg_o         = res_o[WIDTH-1];
    zero_o        = ~|res_o;
    ovf_o         = (a_i[WIDTH-1] == msb_b) && (res_o[WIDTH-1] != a_i[WIDTH-1]);
    flags_valid_o = ~dec_i;
  end

  logic [WIDTH:0] chk_sum;
  always_comb begin
    chk_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
    if (!dec_i && !sub_i) begin
      a_r1_bin_sum: assert ({carry_o, res_o} == chk_sum);
      a_r3_ovf_sign: assert (!ovf_o || (res_o[WIDTH-1] != a_i[WIDTH-1]));
    end
  end
endmodule

// File: tb/test_dec_bin_addsub.sv
module test_dec_bin_addsub;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] a, b, res;
  logic cin, sub, dec, cout, zf, vf, nf, fv;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  dec_bin_addsub i_dec_bin_addsub (
    .a_i(a), .b_i(b), .carry_i(cin), .sub_i(sub), .dec_i(dec),
    .res_o(res), .carry_o(cout), .zero_o(zf), .ovf_o(vf), .neg_o(nf),
    .flags_valid_o(fv)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%02h b=%02h c=%0d sub=%0d dec=%0d actual=%0h expected=%0h",
               req, a, b, cin, sub, dec, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic apply(input int ia, input int ib, input int ic, input int is, input int id);
    int r, c, sa, sb, sr, bb;
    string rq;
    @(posedge clk);
    a = 8'(ia); b = 8'(ib); cin = ic[0]; sub = is[0]; dec = id[0];
    if (id == 0) begin
      if (is == 0) begin
        r = ia + ib + ic; c = (r > 255); r = r & 255; rq = "R1";
      end else begin
        r = ia - ib - (1 - ic); c = (r >= 0); r = r & 255; rq = "R2";
      end
    end else begin
      sa = (ia >> 4) * 10 + (ia & 15);
      sb = (ib >> 4) * 10 + (ib & 15);
      if (is == 0) begin
        sr = sa + sb + ic; c = (sr >= 100); rq = "R5";
      end else begin
        sr = sa - sb - (1 - ic); c = (sr >= 0); rq = "R6";
      end
      r = to_bcd((sr + 100) % 100);
    end
    @(negedge clk);
    chk({rq, "/R8 result"}, int'(res), r);
    chk({rq, " carry"}, int'(cout), c);
    chk("R7 flags_valid", int'(fv), (id == 0) ? 1 : 0);
    if (id == 0) begin
      bb = (is != 0) ? (~ib & 255) : ib;
      sa = (ia >> 7) & 1; sb = (bb >> 7) & 1; sr = (r >> 7) & 1;
      chk("R3 overflow", int'(vf), ((sa == sb) && (sr != sa)) ? 1 : 0);
      chk("R4 negative", int'(nf), sr);
      chk("R4 zero", int'(zf), (r == 0) ? 1 : 0);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; sub = 1'b0; dec = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 reset zero", int'(zf), 1);
    chk("R7 reset valid", int'(fv), 1);
    chk("R1 reset result", int'(res), 0);
    // corner cases
    apply(8'h99, 8'h01, 0, 0, 1);
    apply(8'h99, 8'h99, 1, 0, 1);
    apply(8'h00, 8'h99, 0, 1, 1);
    apply(8'h00, 8'h01, 1, 1, 1);
    apply(8'h7f, 8'h01, 0, 0, 0);
    apply(8'h80, 8'h01, 1, 1, 0);
    apply(8'hff, 8'h01, 0, 0, 0);
    // binary space, operation and carry from operand bits
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib++)
        apply(ia, ib, ((ia >> 1) ^ ib) & 1, (ia ^ ib) & 1, 0);
    // every valid BCD pair
    for (int da = 0; da < 100; da++)
      for (int db = 0; db < 100; db++)
        for (int op = 0; op < 2; op++)
          for (int ci = 0; ci < 2; ci++)
            apply(to_bcd(da), to_bcd(db), ci, op, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule